// File: doc/BRIEF.md
# Early-Prompt-Late Replica Tap Generator

This block sits between a local code generator and the correlators of a delay-lock code tracking loop. It takes a replica stream one sample at a time. Each sample carries the replica bit, a gate bit that says which of two time-interleaved codes the current chip belongs to, and a strobe that marks the first sample of each chip. The samples go into a tapped delay line, and the block gives out three replica bits per sample: early, prompt and late. Early leads prompt, and late trails prompt, by a spacing that software sets in whole samples. At 40 samples per chip, the legal range of 2 to 20 samples covers 0.05 to 0.5 chip.

The block also gives out the gate bit of the prompt chip, together with an accumulate enable derived from the selected replica mode. The modes are: first code only, second code only, the combined time-multiplexed code, or a conventional single code. A signed code-phase offset shifts all three taps together, so that a correlation sweep can step the prompt tap across a chip range. Loading a new offset marks the outputs invalid for one chip, which lets the correlators discard mixed data.

Top module: `epl_tap_gen`

## Requirements
- R1: With offset zero, after each accepted sample (`sample_en` high at a rising edge), `prompt_o` equals the replica bit accepted 40 samples before the most recent one. Here 40 is the half-span of the delay line, which is the largest spacing plus the largest offset.
- R2: `early_o` is the replica bit from `spacing` samples fewer back than prompt, and `late_o` the bit from `spacing` samples more back, where `spacing` is the active spacing.
- R3: A spacing request below 2 is taken as 2, and a request above 20 is taken as 20.
- R4: `spacing_req` is captured only at a rising edge where `sample_en` and `chip_edge` are both high. At every other edge it has no effect on the taps.
- R5: `offset_req` is a signed two's-complement sample count, clamped to the range -20 to +20. It is captured at any rising edge where `offset_ld` is high, whether or not a sample is accepted. A positive value moves all three taps that many samples further back.
- R6: After an offset load, `valid_o` is low until 40 further samples have been accepted, and it goes high with the 40th.
- R7: After reset, the active spacing is 20, the offset is 0, the mode is combined, and the delay line holds zeros. `valid_o` stays low until 81 samples have been accepted.
- R8: `mode_req` is captured with every accepted sample. Its codes are: 0 means first code only, with `acc_en_o` set to the inverse of the prompt gate. 1 means second code only, with `acc_en_o` equal to the prompt gate. 2 means combined, with `acc_en_o` always 1. 3 means single code, with `acc_en_o` always 1. In modes 0 to 2, `gate_o` is the gate bit of the prompt sample. In mode 3, `gate_o` is forced to 0.
- R9: An edge with `sample_en` low and `offset_ld` low changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sample_en | input | 1 | Accept one replica sample at this edge |
| rep_bit | input | 1 | Replica bit of the offered sample |
| rep_gate | input | 1 | Interleave gate of the offered sample (0 first code, 1 second code) |
| chip_edge | input | 1 | Offered sample is the first of a chip |
| spacing_req | input | 5 | Requested early/late spacing in samples |
| offset_req | input | 6 | Requested signed tap offset in samples |
| offset_ld | input | 1 | Load `offset_req` and start a one-chip flush |
| mode_req | input | 2 | Replica mode code |
| early_o | output | 1 | Early replica bit |
| prompt_o | output | 1 | Prompt replica bit |
| late_o | output | 1 | Late replica bit |
| gate_o | output | 1 | Gate bit of the prompt chip |
| acc_en_o | output | 1 | Prompt sample belongs to the selected code |
| valid_o | output | 1 | Taps hold settled data |

## Verification
The bench checks spacing requests that change in the middle of a chip. A design that captured them early would move the early and late taps before the chip boundary. It also checks requests of 0 and 31. A design without clamping would reach past the delay line, or collapse early onto prompt. Offset loads are applied both in idle cycles and with a sample, and at both clamp limits. A wrong sign or a missing clamp would misplace all three taps, and a flush count that is off by one would raise `valid_o` one sample early or late. All four modes are run with alternating gates, so that an inverted gate or an unforced single-code gate shows up in `acc_en_o` or `gate_o`.

// File: rtl/epl_tap_pkg.sv
package epl_tap_pkg;

  typedef enum logic [1:0] {
    MODE_FIRST  = 2'd0,
    MODE_SECOND = 2'd1,
    MODE_BOTH   = 2'd2,
    MODE_SINGLE = 2'd3
  } code_mode_e;

  typedef struct packed {
    logic gt;
    logic val;
  } smp_t;

endpackage

// File: rtl/epl_rst_sync.sv
module epl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/epl_tap_ctl.sv
module epl_tap_ctl
  import epl_tap_pkg::*;
#(
  parameter int SPC     = 40,
  parameter int SP_MIN  = 2,
  parameter int SP_MAX  = 20,
  parameter int OFF_MAX = 20,
  parameter int SPW     = 5,
  parameter int OFW     = 6,
  parameter int DEPTH   = 81,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sample_en,
  input  logic                  chip_edge,
  input  logic [SPW-1:0]        spacing_req,
  input  logic signed [OFW-1:0] offset_req,
  input  logic                  offset_ld,
  input  logic [1:0]            mode_req,
  output logic [SPW-1:0]        sp_o,
  output logic signed [OFW-1:0] off_o,
  output code_mode_e            mode_o,
  output logic                  valid_o
);
  localparam logic [SPW-1:0]        SP_LO  = SPW'(SP_MIN);
  localparam logic [SPW-1:0]        SP_HI  = SPW'(SP_MAX);
  localparam logic signed [OFW-1:0] OFF_HI = OFW'(OFF_MAX);
  localparam logic signed [OFW-1:0] OFF_LO = OFW'(-OFF_MAX);
  localparam logic [CW-1:0]         FILL   = CW'(DEPTH);
  localparam logic [CW-1:0]         FLUSH  = CW'(SPC);

  logic [SPW-1:0]        sp_q, sp_d;
  logic signed [OFW-1:0] off_q, off_d;
  code_mode_e            mode_q, mode_d;
  logic [CW-1:0]         cnt_q, cnt_d;
  logic                  sp_en, off_en, mode_en;

  // clock enables
  assign sp_en   = sample_en & chip_edge;
  assign off_en  = offset_ld;
  assign mode_en = sample_en;

  // next state
  always_comb begin
    if (spacing_req < SP_LO)      sp_d = SP_LO;
    else if (spacing_req > SP_HI) sp_d = SP_HI;
    else                          sp_d = spacing_req;

    if (offset_req > OFF_HI)      off_d = OFF_HI;
    else if (offset_req < OFF_LO) off_d = OFF_LO;
    else                          off_d = offset_req;

    mode_d = code_mode_e'(mode_req);

    if (offset_ld)                       cnt_d = FLUSH;
    else if (sample_en && cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    else                                 cnt_d = cnt_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q   <= SP_HI;
      off_q  <= '0;
      mode_q <= MODE_BOTH;
      cnt_q  <= FILL;
    end else begin
      if (sp_en)   sp_q   <= sp_d;
      if (off_en)  off_q  <= off_d;
      if (mode_en) mode_q <= mode_d;
      cnt_q <= cnt_d;
    end
  end

  assign sp_o    = sp_q;
  assign off_o   = off_q;
  assign mode_o  = mode_q;
  assign valid_o = (cnt_q == '0);

  // R4: spacing moves only at an accepted chip-start sample
  a_r4_sp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_en && chip_edge) |=> $stable(sp_q));
  // R3: active spacing within legal range
  a_r3_sp_range: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_q >= SP_LO) && (sp_q <= SP_HI));
  // R5: active offset within legal range
  a_r5_off_range: assert property (@(posedge clk) disable iff (!rst_n)
    (off_q >= OFF_LO) && (off_q <= OFF_HI));
  // R6: an offset load always drops valid
  a_r6_flush_low: assert property (@(posedge clk) disable iff (!rst_n)
    offset_ld |=> !valid_o);
  // R6: flush counts one per accepted sample
  a_r6_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && !offset_ld && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/epl_delay_line.sv
module epl_delay_line
  import epl_tap_pkg::*;
#(
  parameter int DEPTH = 81
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  smp_t              din,
  output smp_t [DEPTH-1:0]  line_o
);
  smp_t [DEPTH-1:0] line_q;

  generate
    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
      smp_t stage_d;
      if (k == 0) begin : g_head
        assign stage_d = din;
      end else begin : g_body
        assign stage_d = line_q[k-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        line_q[k] <= '0;
        else if (shift_en) line_q[k] <= stage_d;
      end
    end
  endgenerate

  assign line_o = line_q;

  // R1: newest stage takes the offered sample
  a_r1_head: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (line_q[0] == $past(din)));
  // R9: no sample, no movement
  a_r9_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(line_q));
endmodule

// File: rtl/epl_tap_mux.sv
module epl_tap_mux
  import epl_tap_pkg::*;
#(
  parameter int DEPTH  = 81,
  parameter int CENTER = 40,
  parameter int SPW    = 5,
  parameter int OFW    = 6,
  localparam int IDXW  = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  smp_t [DEPTH-1:0]      line_i,
  input  logic [SPW-1:0]        sp_i,
  input  logic signed [OFW-1:0] off_i,
  input  code_mode_e            mode_i,
  output logic                  early_o,
  output logic                  prompt_o,
  output logic                  late_o,
  output logic                  gate_o,
  output logic                  acc_en_o
);
  logic [IDXW-1:0] idx_e, idx_p, idx_l;
  smp_t            tap_e, tap_p, tap_l;

  assign idx_p = IDXW'(CENTER + int'(off_i));
  assign idx_e = IDXW'(CENTER + int'(off_i) - int'(sp_i));
  assign idx_l = IDXW'(CENTER + int'(off_i) + int'(sp_i));

  assign tap_e = line_i[idx_e];
  assign tap_p = line_i[idx_p];
  assign tap_l = line_i[idx_l];

  always_comb begin
    early_o  = tap_e.val;
    prompt_o = tap_p.val;
    late_o   = tap_l.val;
    gate_o   = tap_p.gt;
    acc_en_o = 1'b1;
    unique case (mode_i)
      MODE_FIRST:  acc_en_o = ~tap_p.gt;
      MODE_SECOND: acc_en_o = tap_p.gt;
      MODE_BOTH:   acc_en_o = 1'b1;
      MODE_SINGLE: begin
        acc_en_o = 1'b1;
        gate_o   = 1'b0;
      end
      default:     acc_en_o = 1'b1;
    endcase
  end

  // R8: single-code mode never reports the second code
  a_r8_single_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_SINGLE) |-> !gate_o);
  // R8: combined and single modes integrate every sample
  a_r8_acc_all: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_BOTH || mode_i == MODE_SINGLE) |-> acc_en_o);
  // R2: taps stay inside the delay line
  a_r2_tap_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(idx_e) < DEPTH) && (int'(idx_l) < DEPTH) && (idx_e <= idx_p) && (idx_p <= idx_l));
endmodule

// File: rtl/epl_tap_gen.sv
module epl_tap_gen
  import epl_tap_pkg::*;
#(
  parameter int SPC     = 40,
  parameter int SP_MIN  = 2,
  parameter int SP_MAX  = 20,
  parameter int OFF_MAX = 20,
  parameter int SPW     = 5,
  parameter int OFW     = 6,
  localparam int CENTER = SP_MAX + OFF_MAX,
  localparam int DEPTH  = 2 * CENTER + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sample_en,
  input  logic                  rep_bit,
  input  logic                  rep_gate,
  input  logic                  chip_edge,
  input  logic [SPW-1:0]        spacing_req,
  input  logic signed [OFW-1:0] offset_req,
  input  logic                  offset_ld,
  input  logic [1:0]            mode_req,
  output logic                  early_o,
  output logic                  prompt_o,
  output logic                  late_o,
  output logic                  gate_o,
  output logic                  acc_en_o,
  output logic                  valid_o
);
  logic                  rst_sn;
  logic [SPW-1:0]        sp;
  logic signed [OFW-1:0] off;
  code_mode_e            mode;
  smp_t                  din;
  smp_t [DEPTH-1:0]      line;

  assign din.gt  = rep_gate;
  assign din.val = rep_bit;

  epl_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  epl_tap_ctl #(
    .SPC(SPC), .SP_MIN(SP_MIN), .SP_MAX(SP_MAX), .OFF_MAX(OFF_MAX),
    .SPW(SPW), .OFW(OFW), .DEPTH(DEPTH)
  ) u_ctl (
    .clk         (clk),
    .rst_n       (rst_sn),
    .sample_en   (sample_en),
    .chip_edge   (chip_edge),
    .spacing_req (spacing_req),
    .offset_req  (offset_req),
    .offset_ld   (offset_ld),
    .mode_req    (mode_req),
    .sp_o        (sp),
    .off_o       (off),
    .mode_o      (mode),
    .valid_o     (valid_o)
  );

  epl_delay_line #(.DEPTH(DEPTH)) u_line (
    .clk      (clk),
    .rst_n    (rst_sn),
    .shift_en (sample_en),
    .din      (din),
    .line_o   (line)
  );

  epl_tap_mux #(
    .DEPTH(DEPTH), .CENTER(CENTER), .SPW(SPW), .OFW(OFW)
  ) u_mux (
    .clk      (clk),
    .rst_n    (rst_sn),
    .line_i   (line),
    .sp_i     (sp),
    .off_i    (off),
    .mode_i   (mode),
    .early_o  (early_o),
    .prompt_o (prompt_o),
    .late_o   (late_o),
    .gate_o   (gate_o),
    .acc_en_o (acc_en_o)
  );
endmodule

// File: tb/epl_tap_gen_tb.sv
module epl_tap_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CTR = 40;

  logic clk, rst_n, sample_en, rep_bit, rep_gate, chip_edge, offset_ld;
  logic [4:0] spacing_req;
  logic signed [5:0] offset_req;
  logic [1:0] mode_req;
  logic early_o, prompt_o, late_o, gate_o, acc_en_o, valid_o;

  epl_tap_gen u_dut (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .rep_bit(rep_bit),
    .rep_gate(rep_gate), .chip_edge(chip_edge), .spacing_req(spacing_req),
    .offset_req(offset_req), .offset_ld(offset_ld), .mode_req(mode_req),
    .early_o(early_o), .prompt_o(prompt_o), .late_o(late_o),
    .gate_o(gate_o), .acc_en_o(acc_en_o), .valid_o(valid_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct {
    logic e, p, l, g, a, v;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, failures = 0;
  logic hb[0:4095];
  logic hg[0:4095];
  int ns = 0, chip_idx = 0;
  int m_sp = 20, m_off = 0, m_cnt = 81, m_mode = 2;
  logic [9:0] lfsr = 10'h2F1;
  string phase = "R7";
  bit done = 0;

  function automatic int clampi(int v, int lo, int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  function automatic logic hbit(int i);
    return (i < 0) ? 1'b0 : hb[i];
  endfunction

  function automatic logic hgat(int i);
    return (i < 0) ? 1'b0 : hg[i];
  endfunction

  task automatic chk(string tag, string fld, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, fld, act, exp);
    end
  endtask

  // model output after the latest edge
  task automatic push_exp();
    exp_t x;
    int last, dp;
    logic pg;
    last = ns - 1;
    dp = CTR + m_off;
    x.e = hbit(last - (dp - m_sp));
    x.p = hbit(last - dp);
    x.l = hbit(last - (dp + m_sp));
    pg  = hgat(last - dp);
    x.g = (m_mode == 3) ? 1'b0 : pg;
    case (m_mode)
      0: x.a = ~pg;
      1: x.a = pg;
      default: x.a = 1'b1;
    endcase
    x.v = (m_cnt == 0);
    x.tag = phase;
    q.push_back(x);
  endtask

  task automatic send(logic b, logic g, logic e, int sp, int off, logic ld, int mode);
    sample_en = 1'b1; rep_bit = b; rep_gate = g; chip_edge = e;
    spacing_req = 5'(sp); offset_req = 6'(off); offset_ld = ld; mode_req = 2'(mode);
    @(posedge clk); #1;
    hb[ns] = b; hg[ns] = g; ns++;
    if (e) m_sp = clampi(sp, 2, 20);
    m_mode = mode;
    if (ld) begin m_off = clampi(off, -20, 20); m_cnt = 40; end
    else if (m_cnt > 0) m_cnt--;
    push_exp();
    sample_en = 1'b0; offset_ld = 1'b0;
  endtask

  task automatic idle(int n, logic ld, int off);
    for (int i = 0; i < n; i++) begin
      sample_en = 1'b0; offset_ld = ld; offset_req = 6'(off);
      spacing_req = 5'd7; chip_edge = 1'b1; mode_req = 2'd3;
      @(posedge clk); #1;
      if (ld) begin m_off = clampi(off, -20, 20); m_cnt = 40; end
      push_exp();
      offset_ld = 1'b0;
    end
  endtask

  task automatic run_chips(int nch, int sp, int sp_noise, int mode, bit fine);
    for (int c = 0; c < nch; c++) begin
      logic cb;
      lfsr = {lfsr[8:0], lfsr[9] ^ lfsr[6]};
      cb = lfsr[0];
      for (int s = 0; s < 40; s++) begin
        logic b;
        if (fine) begin
          lfsr = {lfsr[8:0], lfsr[9] ^ lfsr[6]};
          b = lfsr[0];
        end else b = cb;
        send(b, 1'(chip_idx & 1), (s == 0), (s == 0) ? sp : sp_noise, 0, 1'b0, mode);
      end
      chip_idx++;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t x;
      x = q.pop_front();
      chk({x.tag, "/R2"}, "early", early_o, x.e);
      chk({x.tag, "/R1"}, "prompt", prompt_o, x.p);
      chk({x.tag, "/R2"}, "late", late_o, x.l);
      chk({x.tag, "/R8"}, "gate", gate_o, x.g);
      chk({x.tag, "/R8"}, "acc_en", acc_en_o, x.a);
      chk({x.tag, "/R6"}, "valid", valid_o, x.v);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sample_en = 1'b0; rep_bit = 1'b0; rep_gate = 1'b0;
    chip_edge = 1'b0; spacing_req = 5'd0; offset_req = '0; offset_ld = 1'b0;
    mode_req = 2'd2;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R7: reset state
    chk("R7", "valid", valid_o, 1'b0);
    chk("R7", "prompt", prompt_o, 1'b0);
    chk("R7", "late", late_o, 1'b0);
    // R7 fill, R1 default taps, R4 noise mid-chip
    phase = "R7"; run_chips(3, 20, 5, 2, 0);
    phase = "R3"; run_chips(2, 31, 2, 2, 1);   // R3 high clamp
    run_chips(2, 0, 20, 0, 1);                   // R3 low clamp, R8 first code
    phase = "R4"; run_chips(2, 10, 3, 1, 0);   // R4 mid-chip ignored, R8 second code
    phase = "R5"; idle(1, 1'b1, 25);           // R5 idle load, clamp +20
    run_chips(2, 10, 10, 3, 1);                  // R6 flush, R8 single code
    send(1'b1, 1'(chip_idx & 1), 1'b1, 2, -31, 1'b1, 2); // R5 load with sample, clamp -20
    run_chips(2, 2, 17, 2, 1);
    phase = "R9"; idle(5, 1'b0, 0);            // R9 idle holds
    phase = "R5"; idle(1, 1'b1, 5);
    run_chips(2, 15, 4, 2, 1);
    phase = "R6"; send(1'b0, 1'b0, 1'b1, 6, -5, 1'b1, 0);
    run_chips(2, 6, 19, 0, 0);
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule